// File: doc/BRIEF.md
# Staggered PWM LED Dimmer with Fade and Blink

This block drives eight LED sink enables from 8-bit intensity values. A shared 256-step counter advances once per step enable. Each channel compares its own phase of that counter against a latched duty value. Channel n runs one eighth of a period behind channel n-1, so the on-times of the channels never start together and the supply sees spread-out current edges. Each channel takes its intensity either from its own individual value or from one common value shared by all channels. The select is one bit per channel.

Two overlays act on the raw intensity. The first is a fade engine. It ramps a channel in 16 equal steps when the common value leaves or reaches zero, or when the global enable rises or falls. The length of the ramp comes from a 3-bit code counted in millisecond ticks. The second is a blink gate. It switches whole PWM periods on and off from a millisecond counter that all channels share, so channels with equal settings blink in step.

The block has no data stream: every pin is a plain level or single-cycle pulse with no valid/ready handshake. Register values are expected to be held steady between writes. A change of an individual value is treated as a write.

Top module: `staggered_led_dimmer`

## Requirements
- R1: A latched duty value v in 0x00..0xFE gives exactly v on-steps per 256-step channel period. The value 0xFF keeps the channel on for all 256 steps.
- R2: The step counter p is 0 when reset is released and advances by one (mod 256) at each clock edge with `step_en` high. Channel n is on when ((p - 32n) mod 256) < v. While `step_en` is low, every output holds its value.
- R3: A channel samples a new intensity only when its phase wraps to 0. A change made in the middle of a channel period leaves the remainder of that period unchanged.
- R4: When `sel_common[n]` is 1, channel n uses `common_duty`. When it is 0, channel n uses byte n of `ind_duty` (bits 8n+7..8n).
- R5: A fade moves a level k from 0 to 16 or from 16 to 0 in steps of one. A channel at level k produces floor(b*k/16) on-steps, and at level 16 it produces b exactly. One step is taken every FADE_UNIT_MS << (c-1) millisecond ticks for fade code c = 1..5; codes 6 and 7 act as 5. Code 0 makes every transition immediate. The default FADE_UNIT_MS of 16 gives ramps of 256 to 4096 ms.
- R6: When `common_duty` goes from zero to nonzero, the channels that select it fade in from 0. When it goes from nonzero to zero, they fade out from their present intensity. Channels on individual values are unaffected in both cases.
- R7: A rising `enable` fades every channel in to its selected value. A falling `enable` fades every channel out from its present intensity. Once that fade-out ends, all outputs stay off while `enable` is low.
- R8: A change of an individual value on a channel that is fading in ends the fade: the next period uses the new value at full scale. During the fade-out that follows a falling `enable`, such a change turns the channel off from its next period.
- R9: Blink period codes 1..5 select BLINK_UNIT_MS << (code-1) ms; codes 0, 6 and 7 disable blinking. Duty codes 0..3 select an on-phase of 1/16, 1/8, 1/4 or 1/2 of the blink period, at the start of the period. During the off-phase the channel is off for whole periods, even at 0xFF.
- R10: All channels read the blink position from one millisecond counter, sampled when the global step counter wraps. Channels with equal blink codes are therefore on or off in the same global period.
- R11: Out of reset all outputs are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advances the PWM step counter by one |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| enable | input | 1 | Global enable; low means shutdown |
| fade_code | input | 3 | Fade ramp length code, 0 = no fading |
| common_duty | input | 8 | Shared intensity value |
| ind_duty | input | 8*NCH | Individual intensity values, byte n for channel n |
| sel_common | input | NCH | Per-channel select: 1 = common value |
| blink_period | input | 3*NCH | Blink period code, bits 3n+2..3n for channel n |
| blink_duty | input | 2*NCH | Blink on-fraction code, bits 2n+1..2n for channel n |
| led_drv | output | NCH | Sink enable per channel |

## Verification
The bench builds the block with NCH=8, FADE_UNIT_MS=1 and BLINK_UNIT_MS=16, and pulses the millisecond tick once every 256 clocks. With these values one fade step lasts about one PWM period at code 1, so a full ramp fits in about sixteen channel periods. A 16 ms blink period spans sixteen PWM periods, so every ramp and blink cycle can be observed window by window. Under these settings the intensity sweep covers all eight phase offsets against fifty-two duty patterns, including 0x00 and 0xFF.

// File: rtl/ledpwm_pkg.sv
package ledpwm_pkg;
  localparam int DUTY_W   = 8;
  localparam int PERIOD   = 1 << DUTY_W;
  localparam int LVL_W    = 5;
  localparam int LVL_FULL = 16;

  typedef enum logic [1:0] {FM_IDLE, FM_UP, FM_DOWN} fade_mode_e;

  // intensity at fade level lvl out of 16
  function automatic logic [DUTY_W-1:0] scale_duty(input logic [DUTY_W-1:0] b,
                                                   input logic [LVL_W-1:0] lvl);
    logic [DUTY_W+LVL_W-1:0] prod;
    if (lvl >= LVL_W'(LVL_FULL)) return b;
    prod = (DUTY_W+LVL_W)'(b) * (DUTY_W+LVL_W)'(lvl);
    return prod[DUTY_W+3:4];
  endfunction
endpackage

// File: rtl/ledpwm_timebase.sv
module ledpwm_timebase
  import ledpwm_pkg::*;
#(
  parameter int FADE_UNIT_MS  = 16,
  parameter int BLINK_UNIT_MS = 256,
  localparam int FW = $clog2(FADE_UNIT_MS*16+1),
  localparam int BW = $clog2(BLINK_UNIT_MS*16)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              ms_tick,
  input  logic [2:0]        fade_code,
  output logic [DUTY_W-1:0] cnt,
  output logic              fade_tick,
  output logic [BW-1:0]     blink_pos
);
  logic [FW-1:0] fcnt, lim;
  logic [2:0]    code_c;
  logic [BW-1:0] bms, snap;
  logic          wrap;

  assign wrap = step_en && (cnt == '1);

  always_comb begin
    code_c = (fade_code > 3'd5) ? 3'd5 : fade_code;
    lim    = FW'(FADE_UNIT_MS) << (code_c - 3'd1);
  end

  assign fade_tick = ms_tick && (fade_code != 3'd0) && (fcnt >= lim - FW'(1));
  assign blink_pos = wrap ? bms : snap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      fcnt <= '0;
      bms  <= '0;
      snap <= '0;
    end else begin
      if (step_en) cnt <= cnt + DUTY_W'(1);
      if (fade_code == 3'd0) fcnt <= '0;
      else if (ms_tick) fcnt <= fade_tick ? '0 : fcnt + FW'(1);
      if (ms_tick) bms <= bms + BW'(1);
      if (wrap) snap <= bms;
    end
  end

  p_step_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> cnt == $past(cnt) + DUTY_W'(1));
  p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt));
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(snap));
endmodule

// File: rtl/ledpwm_fade.sv
module ledpwm_fade
  import ledpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              en_rise,
  input  logic              en_fall,
  input  logic              sel_common,
  input  logic              com_rise,
  input  logic              com_fall,
  input  logic              ind_wr,
  input  logic              fade_on,
  input  logic              fade_tick,
  input  logic [DUTY_W-1:0] src,
  output logic [DUTY_W-1:0] req
);
  fade_mode_e        mode;
  logic [LVL_W-1:0]  lvl;
  logic [DUTY_W-1:0] base;
  logic              evt;

  localparam logic [LVL_W-1:0] FULL = LVL_W'(LVL_FULL);

  assign evt = en_rise || en_fall || ind_wr || (sel_common && (com_rise || com_fall));
  assign req = scale_duty(base, lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= FM_IDLE;
      lvl  <= '0;
      base <= '0;
    end else if (en_fall) begin
      if (fade_on) mode <= FM_DOWN;
      else begin
        mode <= FM_IDLE;
        lvl  <= '0;
      end
    end else if (en_rise) begin
      base <= src;
      if (fade_on) begin
        mode <= FM_UP;
        lvl  <= '0;
      end else begin
        mode <= FM_IDLE;
        lvl  <= FULL;
      end
    end else if (!en) begin
      if (ind_wr && !sel_common && mode == FM_DOWN) begin
        mode <= FM_IDLE;
        lvl  <= '0;
      end else if (mode == FM_DOWN) begin
        if (fade_tick) begin
          if (lvl <= LVL_W'(1)) begin
            lvl  <= '0;
            mode <= FM_IDLE;
          end else lvl <= lvl - LVL_W'(1);
        end
      end else begin
        mode <= FM_IDLE;
        lvl  <= '0;
      end
    end else if (sel_common && com_fall) begin
      if (fade_on) mode <= FM_DOWN;
      else begin
        base <= src;
        lvl  <= FULL;
        mode <= FM_IDLE;
      end
    end else if (sel_common && com_rise) begin
      base <= src;
      if (fade_on) begin
        mode <= FM_UP;
        lvl  <= '0;
      end else begin
        mode <= FM_IDLE;
        lvl  <= FULL;
      end
    end else if (ind_wr && !sel_common && mode != FM_IDLE) begin
      base <= src;
      lvl  <= FULL;
      mode <= FM_IDLE;
    end else begin
      unique case (mode)
        FM_IDLE: begin
          base <= src;
          lvl  <= FULL;
        end
        FM_UP: begin
          base <= src;
          if (fade_tick) begin
            if (lvl >= FULL - LVL_W'(1)) begin
              lvl  <= FULL;
              mode <= FM_IDLE;
            end else lvl <= lvl + LVL_W'(1);
          end
        end
        default: begin
          if (fade_tick) begin
            if (lvl <= LVL_W'(1)) begin
              lvl  <= '0;
              mode <= FM_IDLE;
            end else lvl <= lvl - LVL_W'(1);
          end
        end
      endcase
    end
  end

  p_lvl_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= FULL);
  p_up_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_UP && !evt) |=> lvl >= $past(lvl));
  p_down_monotone_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FM_DOWN && !evt) |=> lvl <= $past(lvl));
  p_cancel_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_fall && ind_wr && !sel_common && mode == FM_DOWN) |=> req == '0);
endmodule

// File: rtl/ledpwm_chan.sv
module ledpwm_chan
  import ledpwm_pkg::*;
#(
  parameter int CH            = 0,
  parameter int NCH           = 8,
  parameter int BLINK_UNIT_MS = 256,
  localparam int BW = $clog2(BLINK_UNIT_MS*16),
  localparam int PW = BW + 1,
  localparam logic [DUTY_W-1:0] OFFS = DUTY_W'(CH * (PERIOD / NCH))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [DUTY_W-1:0] cnt,
  input  logic [DUTY_W-1:0] req,
  input  logic [BW-1:0]     blink_pos,
  input  logic [2:0]        per_code,
  input  logic [1:0]        duty_code,
  output logic              drv
);
  logic [DUTY_W-1:0] phase, lat;
  logic [PW-1:0]     plen, olen, pos;
  logic              start, gate, blink_now;

  assign phase = cnt - OFFS;
  assign start = step_en && (phase == '1);

  always_comb begin
    plen      = '0;
    olen      = '0;
    pos       = '0;
    blink_now = 1'b1;
    if (per_code >= 3'd1 && per_code <= 3'd5) begin
      plen      = PW'(BLINK_UNIT_MS) << (per_code - 3'd1);
      olen      = plen >> (3'd4 - {1'b0, duty_code});
      pos       = {1'b0, blink_pos} & (plen - PW'(1));
      blink_now = pos < olen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat  <= '0;
      gate <= 1'b1;
    end else if (start) begin
      lat  <= req;
      gate <= blink_now;
    end
  end

  assign drv = gate && ((lat == '1) || (phase < lat));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(lat) && $stable(gate)));
  p_zero_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lat == '0) |-> !drv);
  p_full_lit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && lat == '1) |-> drv);
  p_blink_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |-> !drv);
endmodule

// File: rtl/staggered_led_dimmer.sv
module staggered_led_dimmer
  import ledpwm_pkg::*;
#(
  parameter int NCH           = 8,
  parameter int FADE_UNIT_MS  = 16,
  parameter int BLINK_UNIT_MS = 256,
  localparam int BW = $clog2(BLINK_UNIT_MS*16)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_en,
  input  logic                ms_tick,
  input  logic                enable,
  input  logic [2:0]          fade_code,
  input  logic [DUTY_W-1:0]   common_duty,
  input  logic [NCH*DUTY_W-1:0] ind_duty,
  input  logic [NCH-1:0]      sel_common,
  input  logic [NCH*3-1:0]    blink_period,
  input  logic [NCH*2-1:0]    blink_duty,
  output logic [NCH-1:0]      led_drv
);
  logic [DUTY_W-1:0]     cnt, com_q;
  logic [NCH*DUTY_W-1:0] ind_q;
  logic [BW-1:0]         blink_pos;
  logic                  fade_tick, en_q, en_rise, en_fall, com_rise, com_fall, fade_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      com_q <= '0;
      ind_q <= '0;
    end else begin
      en_q  <= enable;
      com_q <= common_duty;
      ind_q <= ind_duty;
    end
  end

  assign en_rise  = enable && !en_q;
  assign en_fall  = !enable && en_q;
  assign com_rise = (com_q == '0) && (common_duty != '0);
  assign com_fall = (com_q != '0) && (common_duty == '0);
  assign fade_on  = fade_code != 3'd0;

  ledpwm_timebase #(.FADE_UNIT_MS(FADE_UNIT_MS), .BLINK_UNIT_MS(BLINK_UNIT_MS)) u_tb (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ms_tick(ms_tick),
    .fade_code(fade_code), .cnt(cnt), .fade_tick(fade_tick), .blink_pos(blink_pos)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [DUTY_W-1:0] src, req;
    logic              ind_wr;

    assign src    = sel_common[n] ? common_duty : ind_duty[n*DUTY_W +: DUTY_W];
    assign ind_wr = ind_duty[n*DUTY_W +: DUTY_W] != ind_q[n*DUTY_W +: DUTY_W];

    ledpwm_fade u_fade (
      .clk(clk), .rst_n(rst_n), .en(enable), .en_rise(en_rise), .en_fall(en_fall),
      .sel_common(sel_common[n]), .com_rise(com_rise), .com_fall(com_fall),
      .ind_wr(ind_wr), .fade_on(fade_on), .fade_tick(fade_tick), .src(src), .req(req)
    );

    ledpwm_chan #(.CH(n), .NCH(NCH), .BLINK_UNIT_MS(BLINK_UNIT_MS)) u_chan (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .cnt(cnt), .req(req),
      .blink_pos(blink_pos), .per_code(blink_period[n*3 +: 3]),
      .duty_code(blink_duty[n*2 +: 2]), .drv(led_drv[n])
    );
  end

  p_reset_dark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> led_drv == '0);
endmodule

// File: tb/staggered_led_dimmer_test.sv
module staggered_led_dimmer_test;
  localparam int NCH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             step_en = 1'b1;
  logic             ms_tick = 1'b0;
  logic             enable = 1'b0;
  logic [2:0]       fade_code = '0;
  logic [7:0]       common_duty = '0;
  logic [NCH*8-1:0] ind_duty = '0;
  logic [NCH-1:0]   sel_common = '0;
  logic [NCH*3-1:0] blink_period = '0;
  logic [NCH*2-1:0] blink_duty = '0;
  logic [NCH-1:0]   led_drv;

  staggered_led_dimmer #(.NCH(NCH), .FADE_UNIT_MS(1), .BLINK_UNIT_MS(16)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .ms_tick(ms_tick), .enable(enable),
    .fade_code(fade_code), .common_duty(common_duty), .ind_duty(ind_duty),
    .sel_common(sel_common), .blink_period(blink_period), .blink_duty(blink_duty),
    .led_drv(led_drv)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, mcyc = 0, bcnt = 0, bseen = -1;
  bit ms_run = 0, done = 0;
  int acc [NCH];
  int win [NCH];
  int wlast [NCH];
  int hist [NCH][256];
  int vals [64];

  always @(posedge clk) begin
    if (!rst_n) bcnt <= 0;
    else if (step_en) bcnt <= bcnt + 1;
    cyc <= cyc + 1;
    if (cyc == 190000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    mcyc <= mcyc + 1;
    ms_tick <= ms_run && (mcyc % 256 == 100);
  end

  // per-channel window monitor, windows aligned to each channel's phase 0
  always @(negedge clk) begin
    if (rst_n && bcnt != bseen) begin
      bseen = bcnt;
      for (int n = 0; n < NCH; n++) begin
        int ph;
        ph = (bcnt - 32*n) & 255;
        if (ph == 0) acc[n] = int'(led_drv[n]);
        else acc[n] = acc[n] + int'(led_drv[n]);
        if (ph == 255) begin
          wlast[n] = acc[n];
          hist[n][win[n] % 256] = acc[n];
          win[n] = win[n] + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic collect(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      int w0;
      w0 = win[ch];
      while (win[ch] == w0) @(negedge clk);
      vals[i] = wlast[ch];
    end
  endtask

  task automatic set_ind(input int ch, input int v);
    ind_duty[ch*8 +: 8] = 8'(v);
  endtask

  // ramp shape: monotonic, steps of unit, ends at final value
  task automatic ramp_check(input int n, input int unit, input bit up, input int fin,
                            input int lo, input int hi, input string req);
    int bad, mid;
    bad = 0; mid = 0;
    for (int i = 0; i < n; i++) begin
      if (vals[i] % unit != 0) bad++;
      if (i > 0 && up && vals[i] < vals[i-1]) bad++;
      if (i > 0 && !up && vals[i] > vals[i-1]) bad++;
      if (vals[i] != fin) mid++;
    end
    chk(bad == 0, req, bad, 0);
    chk(vals[n-1] == fin, req, vals[n-1], fin);
    chk(mid >= lo && mid <= hi, req, mid, lo);
  endtask

  initial begin
    for (int n = 0; n < NCH; n++) begin
      acc[n] = 0; win[n] = 0; wlast[n] = 0;
    end
    cycles(5);
    chk(led_drv == '0, "R11 in reset", int'(led_drv), 0);
    rst_n = 1'b1;
    cycles(1);
    chk(led_drv == '0, "R11 after reset", int'(led_drv), 0);
    cycles(300);
    chk(led_drv == '0, "R7 disabled stays dark", int'(led_drv), 0);

    // R1 R2: duty sweep over all phase offsets
    enable = 1'b1;
    for (int d = 0; d < 256; d += 5) begin
      int mism [NCH];
      for (int n = 0; n < NCH; n++) begin
        set_ind(n, (d + 37*n) & 255);
        mism[n] = 0;
      end
      cycles(520);
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        for (int n = 0; n < NCH; n++) begin
          int v, ph;
          bit e;
          v = (d + 37*n) & 255;
          ph = (bcnt - 32*n) & 255;
          e = (v == 255) || (ph < v);
          if (led_drv[n] != e) mism[n]++;
        end
      end
      for (int n = 0; n < NCH; n++) chk(mism[n] == 0, "R1 R2 duty/phase", mism[n], 0);
    end

    // R2: outputs freeze without step enable
    begin
      logic [NCH-1:0] held;
      int diff;
      diff = 0;
      step_en = 1'b0;
      cycles(2);
      held = led_drv;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (led_drv != held) diff++;
      end
      chk(diff == 0, "R2 freeze", diff, 0);
      step_en = 1'b1;
    end

    // R3: change applies from next period only
    set_ind(2, 50);
    collect(2, 3);
    while (((bcnt - 64) & 255) != 100) @(negedge clk);
    set_ind(2, 200);
    collect(2, 2);
    chk(vals[0] == 50, "R3 current period kept", vals[0], 50);
    chk(vals[1] == 200, "R3 next period new", vals[1], 200);

    // R4: common vs individual select
    common_duty = 8'd90;
    sel_common = 8'b0101_0101;
    for (int n = 0; n < NCH; n++) set_ind(n, 20 + n);
    cycles(600);
    for (int n = 0; n < NCH; n++) begin
      int e;
      e = sel_common[n] ? 90 : 20 + n;
      collect(n, 1);
      chk(vals[0] == e, "R4 source select", vals[0], e);
    end

    // R5 R6: common-driven fades
    common_duty = 8'd0;
    cycles(4);
    sel_common = 8'h0F;
    for (int n = 4; n < NCH; n++) set_ind(n, 80);
    cycles(600);
    ms_run = 1'b1;
    fade_code = 3'd1;
    common_duty = 8'd160;
    collect(1, 24);
    ramp_check(24, 10, 1'b1, 160, 14, 18, "R5 R6 fade-in code1");
    chk(wlast[5] == 80, "R6 individual unaffected", wlast[5], 80);
    common_duty = 8'd0;
    collect(1, 22);
    ramp_check(22, 10, 1'b0, 0, 13, 18, "R6 fade-out to zero");
    chk(wlast[5] == 80, "R6 individual unaffected", wlast[5], 80);
    fade_code = 3'd2;
    common_duty = 8'd160;
    collect(1, 40);
    ramp_check(40, 10, 1'b1, 160, 28, 36, "R5 fade-in code2");

    // R7 R8: shutdown fades and cancels
    fade_code = 3'd1;
    enable = 1'b0;
    collect(5, 22);
    ramp_check(22, 5, 1'b0, 0, 13, 18, "R7 shutdown fade-out");
    begin
      int lit;
      lit = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        if (led_drv != '0) lit++;
      end
      chk(lit == 0, "R7 dark after shutdown", lit, 0);
    end
    enable = 1'b1;
    collect(5, 6);
    chk(vals[5] < 80 && vals[5] > 0, "R7 fading in", vals[5], 40);
    set_ind(6, 200);
    collect(6, 2);
    chk(vals[1] == 200, "R8 cancel fade-in", vals[1], 200);
    collect(5, 14);
    chk(vals[13] == 80, "R7 fade-in done", vals[13], 80);
    enable = 1'b0;
    collect(7, 4);
    chk(vals[3] > 0, "R7 fading out", vals[3], 60);
    set_ind(7, 120);
    collect(7, 2);
    chk(vals[1] == 0, "R8 cancel fade-out", vals[1], 0);
    collect(4, 1);
    chk(vals[0] > 0, "R8 other channel still fading", vals[0], 40);

    // R9 R10: blink
    cycles(6000);
    fade_code = 3'd0;
    sel_common = '0;
    for (int n = 0; n < NCH; n++) set_ind(n, 255);
    blink_period[3*3 +: 3] = 3'd1; blink_duty[3*2 +: 2] = 2'd3;
    blink_period[5*3 +: 3] = 3'd1; blink_duty[5*2 +: 2] = 2'd3;
    blink_period[4*3 +: 3] = 3'd1; blink_duty[4*2 +: 2] = 2'd0;
    enable = 1'b1;
    collect(5, 3);
    collect(5, 32);
    begin
      int w5, on3, on4, on6, partial, mism;
      w5 = win[5];
      on3 = 0; on4 = 0; on6 = 0; partial = 0; mism = 0;
      for (int k = w5 - 34; k < w5 - 2; k++) begin
        int h3, h4, h5, h6;
        h3 = hist[3][k % 256]; h4 = hist[4][k % 256];
        h5 = hist[5][k % 256]; h6 = hist[6][k % 256];
        if (h3 == 256) on3++;
        if (h4 == 256) on4++;
        if (h6 == 256) on6++;
        if (h3 != 0 && h3 != 256) partial++;
        if (h4 != 0 && h4 != 256) partial++;
        if (h3 != h5) mism++;
      end
      chk(on3 == 16, "R9 blink half duty", on3, 16);
      chk(on4 == 2, "R9 blink 1/16 duty", on4, 2);
      chk(on6 == 32, "R9 blink disabled", on6, 32);
      chk(partial == 0, "R9 whole periods gated", partial, 0);
      chk(mism == 0, "R10 channels blink in step", mism, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule